// File: doc/BRIEF.md
# Modular LFSR Keystream Sequencer

This block keeps the sixteen 31-bit state cells of a word-oriented stream generator. It computes their feedback modulo the prime 2^31−1 and runs a generation from key loading to continuous keystream. A start pulse loads the cells from a 128-bit key, a 128-bit IV and sixteen 15-bit constants. The block then runs 32 initialization steps, in which the feedback also folds in the nonlinear output. One working step follows whose output is thrown away. After that, each step yields one 32-bit keystream word.

The nonlinear function sits outside the block. Four 32-bit reorganized words taken from the cells drive it, and its 32-bit result returns on `w_i`. A step is taken on every clock where `adv_i` is high and a run is active. The keystream word is `w_i` xor X3, and it is marked valid only in the keystream phase.

Top module: `lfsr_keystream_seq`

## Requirements
- R1: On a `start_i` clock, cell i (i = 0..15) loads {key byte i, constant d_i, IV byte i}, 31 bits, where byte 0 is bits 127:120 of `key_i` / `iv_i`.
- R2: The outputs are formed as follows, where hi(c) = c[30:15] and lo(c) = c[15:0]: `x0_o` = {hi(s15), lo(s14)}, `x1_o` = {lo(s11), hi(s9)}, `x2_o` = {lo(s7), hi(s5)} and `x3_o` = {lo(s2), hi(s0)}.
- R3: Each step computes the new cell as (2^15·s15 + 2^17·s13 + 2^21·s10 + 2^20·s4 + 257·s0) mod (2^31−1). In the initialization phase, (`w_i` >> 1) is added modulo 2^31−1.
- R4: A new cell that is congruent to 0 is stored as 2^31−1, so no cell holds 0 while a run is active.
- R5: On each step the cells move down by one (s1 into s0, and so on), and the new value enters s15.
- R6: `phase_o` shows the run state: 0 = idle, 1 = initialization, 2 = discard step, 3 = keystream. Exactly 32 initialization steps are followed by exactly one discard step, which uses the working-mode feedback. The keystream phase then lasts until the next start.
- R7: `z_valid_o` is high only in the keystream phase, and `z_o` = `w_i` xor `x3_o` there.
- R8: A clock with `adv_i` low changes neither the cells nor the phase.
- R9: A `start_i` pulse in any phase aborts the run, reloads the cells and returns to the initialization phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load the cells and begin initialization |
| key_i | input | 128 | Secret key |
| iv_i | input | 128 | Initialization vector |
| adv_i | input | 1 | `w_i` is valid; take one step |
| w_i | input | 32 | Output of the external nonlinear function |
| x0_o | output | 32 | Reorganized word X0 |
| x1_o | output | 32 | Reorganized word X1 |
| x2_o | output | 32 | Reorganized word X2 |
| x3_o | output | 32 | Reorganized word X3 |
| z_o | output | 32 | Keystream word |
| z_valid_o | output | 1 | Keystream word valid |
| phase_o | output | 2 | Run phase |

## Verification
The assertions assume that `start_i`, `adv_i` and `w_i` carry known values after reset. They also assume that `w_i` is the value meant for the step taken at the same edge. The non-zero-cell property further relies on every load constant being non-zero. The bench drives all inputs on the falling edge and holds them through the next rising edge. It uses only non-zero constants. It also picks a `w_i` value that forces a feedback sum of zero, so the substitution of 2^31−1 is reached through legal stimulus.

// File: rtl/lks_pkg.sv
package lks_pkg;
  localparam int CELL_W  = 31;
  localparam int N_CELLS = 16;
  localparam int WORD_W  = 32;
  localparam int CONST_W = 15;

  typedef logic [CELL_W-1:0] cell_t;
  typedef cell_t [N_CELLS-1:0] cells_t;
  typedef logic [N_CELLS-1:0][CONST_W-1:0] consts_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_DISC = 2'd2,
    PH_KEYS = 2'd3
  } phase_e;

  // element 0 listed last
  localparam consts_t LOAD_CONSTS = {
    15'h47AC, 15'h789A, 15'h3C4D, 15'h5E26, 15'h1AF1, 15'h6BC4, 15'h2F13, 15'h4D78,
    15'h09AF, 15'h7135, 15'h35E2, 15'h5789, 15'h135E, 15'h626B, 15'h26BC, 15'h44D7
  };

  // times 2^k modulo 2^31-1
  function automatic cell_t rotl(cell_t x, int k);
    return cell_t'((x << k) | (x >> (CELL_W - k)));
  endfunction
endpackage

// File: rtl/lks_mod_add.sv
module lks_mod_add
  import lks_pkg::*;
(
  input  cell_t a_i,
  input  cell_t b_i,
  output cell_t sum_o
);
  logic [CELL_W:0] raw;
  assign raw   = {1'b0, a_i} + {1'b0, b_i};
  // end-around carry folds 2^31 back as 1
  assign sum_o = raw[CELL_W-1:0] + {{(CELL_W-1){1'b0}}, raw[CELL_W]};
endmodule

// File: rtl/lks_feedback.sv
module lks_feedback
  import lks_pkg::*;
(
  input  cells_t            cells_i,
  input  logic              init_mode_i,
  input  logic [WORD_W-1:0] w_i,
  output cell_t             s16_o
);
  localparam int N_OPS = 7;

  cell_t ops [N_OPS];
  cell_t acc [N_OPS];
  logic  unused_w0;

  assign unused_w0 = w_i[0];

  always_comb begin
    ops[0] = rotl(cells_i[15], 15);
    ops[1] = rotl(cells_i[13], 17);
    ops[2] = rotl(cells_i[10], 21);
    ops[3] = rotl(cells_i[4], 20);
    ops[4] = rotl(cells_i[0], 8);
    ops[5] = cells_i[0];
    ops[6] = init_mode_i ? w_i[WORD_W-1:1] : '0;
  end

  assign acc[0] = ops[0];

  for (genvar g = 0; g < N_OPS - 1; g++) begin : g_chain
    lks_mod_add u_add (
      .a_i  (acc[g]),
      .b_i  (ops[g+1]),
      .sum_o(acc[g+1])
    );
  end

  assign s16_o = (acc[N_OPS-1] == '0) ? '1 : acc[N_OPS-1];
endmodule

// File: rtl/lks_wordmap.sv
module lks_wordmap
  import lks_pkg::*;
(
  input  cells_t            cells_i,
  output logic [WORD_W-1:0] x0_o,
  output logic [WORD_W-1:0] x1_o,
  output logic [WORD_W-1:0] x2_o,
  output logic [WORD_W-1:0] x3_o
);
  function automatic logic [15:0] hi(cell_t c);
    return c[30:15];
  endfunction

  function automatic logic [15:0] lo(cell_t c);
    return c[15:0];
  endfunction

  assign x0_o = {hi(cells_i[15]), lo(cells_i[14])};
  assign x1_o = {lo(cells_i[11]), hi(cells_i[9])};
  assign x2_o = {lo(cells_i[7]),  hi(cells_i[5])};
  assign x3_o = {lo(cells_i[2]),  hi(cells_i[0])};
endmodule

// File: rtl/lfsr_keystream_seq.sv
module lfsr_keystream_seq
  import lks_pkg::*;
#(
  parameter int      INIT_STEPS = 32,
  parameter consts_t D_CONST    = LOAD_CONSTS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [127:0]  key_i,
  input  logic [127:0]  iv_i,
  input  logic          adv_i,
  input  logic [31:0]   w_i,
  output logic [31:0]   x0_o,
  output logic [31:0]   x1_o,
  output logic [31:0]   x2_o,
  output logic [31:0]   x3_o,
  output logic [31:0]   z_o,
  output logic          z_valid_o,
  output logic [1:0]    phase_o
);
  localparam int CNT_W = $clog2(INIT_STEPS);

  cells_t             cells_q, load_val;
  cell_t              s16;
  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               step;

  always_comb begin
    for (int i = 0; i < N_CELLS; i++)
      load_val[i] = {key_i[127-8*i -: 8], D_CONST[i], iv_i[127-8*i -: 8]};
  end

  lks_feedback u_fb (
    .cells_i    (cells_q),
    .init_mode_i(phase_q == PH_INIT),
    .w_i        (w_i),
    .s16_o      (s16)
  );

  lks_wordmap u_map (
    .cells_i(cells_q),
    .x0_o   (x0_o),
    .x1_o   (x1_o),
    .x2_o   (x2_o),
    .x3_o   (x3_o)
  );

  assign step = adv_i && (phase_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cells_q <= '0;
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      cells_q <= load_val;
      phase_q <= PH_INIT;
      cnt_q   <= '0;
    end else if (step) begin
      cells_q <= {s16, cells_q[N_CELLS-1:1]};
      unique case (phase_q)
        PH_INIT: begin
          if (cnt_q == CNT_W'(INIT_STEPS - 1)) phase_q <= PH_DISC;
          cnt_q <= cnt_q + 1'b1;
        end
        PH_DISC: phase_q <= PH_KEYS;
        default: ;
      endcase
    end
  end

  assign z_valid_o = (phase_q == PH_KEYS);
  assign z_o       = w_i ^ x3_o;
  assign phase_o   = phase_q;

  a_r4_cell_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (cells_q[15] != '0));

  a_r5_shift_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i && phase_q != PH_IDLE) |=> (cells_q[14:0] == $past(cells_q[15:1])));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !start_i) |=> ($stable(cells_q) && $stable(phase_q)));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase_q == PH_INIT && cnt_q == '0));

  a_r6_one_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DISC && adv_i && !start_i) |=> (phase_q == PH_KEYS));

  a_r7_valid_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(z_valid_o) |-> ($past(phase_q) == PH_DISC));
endmodule

// File: tb/lfsr_keystream_seq_bench.sv
module lfsr_keystream_seq_bench;
  localparam longint unsigned P = 64'h7FFF_FFFF;

  typedef struct packed {
    logic [127:0] key;
    logic [127:0] iv;
    logic [31:0]  seed;
  } vec_t;

  localparam vec_t VECS [3] = '{
    '{key: 128'h0, iv: 128'h0, seed: 32'h0000_0001},
    '{key: 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
      iv:  128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, seed: 32'hDEAD_BEEF},
    '{key: 128'h3D4C_4BE9_6A82_FDAE_B58F_641D_B17B_455B,
      iv:  128'h84319AA8_DE69_15CA_1F6B_DA6B_FBD8_C766, seed: 32'h1234_5678}
  };

  localparam logic [14:0] DC [16] = '{
    15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789, 15'h35E2, 15'h7135, 15'h09AF,
    15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1, 15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC
  };

  logic         clk = 0, rst_n = 0, start = 0, adv = 0;
  logic [127:0] key = '0, iv = '0;
  logic [31:0]  w = '0;
  logic [31:0]  x0, x1, x2, x3, z;
  logic         zv;
  logic [1:0]   ph;

  int n_chk = 0, n_bad = 0;
  logic [30:0] m [16];

  always #2 clk = ~clk;

  lfsr_keystream_seq u_lfsr_keystream_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key), .iv_i(iv),
    .adv_i(adv), .w_i(w), .x0_o(x0), .x1_o(x1), .x2_o(x2), .x3_o(x3),
    .z_o(z), .z_valid_o(zv), .phase_o(ph)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned fb_sum(bit init_m, logic [31:0] wv);
    longint unsigned v;
    v = (longint'(m[15]) << 15) + (longint'(m[13]) << 17) + (longint'(m[10]) << 21)
      + (longint'(m[4]) << 20) + longint'(m[0]) * 257;
    if (init_m) v += longint'(wv >> 1);
    return v % P;
  endfunction

  task automatic model_step(bit init_m, logic [31:0] wv);
    longint unsigned r;
    r = fb_sum(init_m, wv);
    if (r == 0) r = P;
    for (int i = 0; i < 15; i++) m[i] = m[i+1];
    m[15] = r[30:0];
  endtask

  function automatic logic [31:0] ex0(); return {m[15][30:15], m[14][15:0]}; endfunction
  function automatic logic [31:0] ex1(); return {m[11][15:0], m[9][30:15]}; endfunction
  function automatic logic [31:0] ex2(); return {m[7][15:0],  m[5][30:15]}; endfunction
  function automatic logic [31:0] ex3(); return {m[2][15:0],  m[0][30:15]}; endfunction

  // called at a falling edge; returns at a falling edge
  task automatic do_start(logic [127:0] k, logic [127:0] v);
    key = k; iv = v; start = 1; adv = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 16; i++) m[i] = {k[127-8*i -: 8], DC[i], v[127-8*i -: 8]};
  endtask

  task automatic do_step(logic [31:0] wv, bit init_m);
    w = wv; adv = 1;
    model_step(init_m, wv);
    @(negedge clk);
    adv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R6 reset phase", 32'(ph), 32'd0);
    chk("R7 reset z_valid", 32'(zv), 32'd0);
    chk("R2 reset x0", x0, 32'd0);
    rst_n = 1;
    @(negedge clk);
    adv = 1; w = 32'hFFFF_FFFF;
    @(negedge clk);
    adv = 0;
    chk("R6 idle ignores adv", 32'(ph), 32'd0);

    foreach (VECS[vi]) begin
      do_start(VECS[vi].key, VECS[vi].iv);
      chk("R1/R2 load x0", x0, ex0());
      chk("R1/R2 load x1", x1, ex1());
      chk("R1/R2 load x2", x2, ex2());
      chk("R1/R2 load x3", x3, ex3());
      chk("R6 init phase", 32'(ph), 32'd1);
      for (int s = 0; s < 32; s++) begin
        chk("R7 no valid in init", 32'(zv), 32'd0);
        do_step(VECS[vi].seed ^ (32'(s) * 32'h9E37_79B9), 1'b1);
        chk("R3/R5 init x0", x0, ex0());
        chk("R3/R5 init x3", x3, ex3());
        if (s == 5) begin
          @(negedge clk);
          chk("R8 hold x0", x0, ex0());
          chk("R8 hold phase", 32'(ph), 32'd1);
        end
        if (s < 31) chk("R6 still init", 32'(ph), 32'd1);
      end
      chk("R6 discard phase", 32'(ph), 32'd2);
      chk("R7 no valid in discard", 32'(zv), 32'd0);
      do_step(32'hA5A5_5A5A, 1'b0);
      chk("R3 discard x0", x0, ex0());
      chk("R6 keystream phase", 32'(ph), 32'd3);
      for (int s = 0; s < 8; s++) begin
        w = VECS[vi].seed + 32'(s) * 32'h0101_0101;
        #1;
        chk("R7 valid", 32'(zv), 32'd1);
        chk("R7 z value", z, w ^ ex3());
        do_step(w, 1'b0);
        chk("R3/R5 work x0", x0, ex0());
        chk("R2 work x1", x1, ex1());
        chk("R2 work x2", x2, ex2());
      end
      chk("R6 stays keystream", 32'(ph), 32'd3);
    end

    // R4: force a zero feedback sum during initialization
    do_start(VECS[2].key, VECS[2].iv);
    begin
      longint unsigned vv, uu;
      vv = fb_sum(1'b0, 32'd0);
      uu = (P - vv) % P;
      do_step({uu[30:0], 1'b0}, 1'b1);
    end
    chk("R4 zero maps to all ones", 32'(x0[31:16]), 32'h0000_FFFF);
    chk("R4 model x0", x0, ex0());

    // R9: abort from keystream
    do_start(VECS[1].key, VECS[1].iv);
    for (int s = 0; s < 33; s++) do_step(32'h0F0F_0000 + 32'(s), s < 32);
    chk("R9 pre-abort phase", 32'(ph), 32'd3);
    do_start(VECS[2].key, VECS[2].iv);
    chk("R9 abort phase", 32'(ph), 32'd1);
    chk("R9 abort valid", 32'(zv), 32'd0);
    chk("R9 reload x0", x0, ex0());
    chk("R9 reload x3", x3, ex3());

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule